// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two 16-bit timer/counters. Each one is kept as a low byte and a high byte. A shared configuration byte sets up both timers, and a shared control byte starts them, stops them and holds their overflow flags. Each timer advances on one of two sources:

- an internal tick, which is the clock divided by a prescale factor (12 by default);
- a falling edge seen on its own external event input.

An optional gate makes counting also depend on a level input being high.

Four count arrangements are available: a 13-bit count, a plain 16-bit count, an 8-bit count that reloads itself from the high byte, and a split arrangement in which timer 0 works as two independent 8-bit counters. Software reads and writes every register through a simple single-cycle port. When a count wraps, hardware sets the timer's flag, and the flag stays set until software writes it to zero.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, every register reads 0x00. The registers are configuration (address 0), control (1), timer 0 low/high (2/3) and timer 1 low/high (4/5).
- R2: A write to a register is visible on the read port in the next cycle.
  - In the configuration byte, bits 7:4 set up timer 0 as {gate, external select, mode[1:0]}, and bits 3:0 set up timer 1 in the same way.
  - In the control byte, bit 7 is timer 1's flag, bit 6 is timer 1's run, bit 5 is timer 0's flag and bit 4 is timer 0's run.
  - Control bits 3:0 always read 0.
- R3: With run set and external select clear, a timer advances by exactly one for every PRESCALE clock cycles.
- R4: While run is clear, the count does not change.
- R5: In mode 01 the 16-bit count wraps from FFFFh to 0000h and sets the timer's flag.
  - The flag stays set while counting continues.
  - Writing 0 to the flag clears it.
  - A hardware set in the same cycle as a write wins.
- R6: In mode 00, the high byte and bits 4:0 of the low byte form a 13-bit count.
  - Low-byte bits 7:5 keep their value.
  - A wrap from all ones sets the flag.
- R7: In mode 10 the low byte counts. When it steps past FFh it is loaded from the high byte, the flag is set, and the high byte is unchanged.
- R8: In mode 11 on timer 0, the low byte counts using timer 0's run, gate and source, and sets timer 0's flag. The high byte counts internal ticks under timer 1's run bit and sets timer 1's flag.
- R9: With external select set, a timer advances once for each high-to-low change of its event input. The input is sampled at internal ticks, and a change counts when the input is high at one tick and low at the next. Rising changes do not count.
- R10: With the gate bit set, a running timer advances only while its gate level input is high.
- R11: Timer 1 holds its count whenever either configuration field selects mode 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for reads |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| ev_in | input | 2 | External event inputs, bit i belongs to timer i |
| gate_lvl | input | 2 | Gate level inputs, bit i belongs to timer i |

## Verification
A register write takes effect at the clock edge that samples it, and it reads back right after that edge. A count step lands on the edge where the internal tick is high, and there is one such edge in every PRESCALE edges. Because of this, the bench never depends on where the prescaler is in its cycle. It opens a run window with one write and closes it with another exactly PRESCALE×N edges later, so exactly N ticks fall inside the window. Each test places its overflow before the last tick, so the flag can be read on the half cycle before the closing edge. External edges are held for three ticks on each side, which covers the two-stage synchroniser and the tick sampling.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the dual timer/counter.
// Assumes byte-wide registers and exactly two timers.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_TMR  = 2;
    localparam int CFG_W  = 4;

    typedef enum logic [1:0] {
        CM_13BIT   = 2'b00,
        CM_16BIT   = 2'b01,
        CM_RELOAD8 = 2'b10,
        CM_SPLIT   = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        cnt_mode_e mode;
    } tmr_cfg_t;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
endpackage

// File: rtl/tmr_tick_gen.sv
// Generates the internal count tick (one cycle in PRESCALE) and detects
// falling edges of the external event inputs, sampled at ticks.
// Assumes event inputs are asynchronous; a two-flop synchroniser is used.
module tmr_tick_gen #(
    parameter int PRESCALE = 12,
    parameter int N_EXT    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_in,
    output logic             tick,
    output logic [N_EXT-1:0] ext_fall
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0]    pre_q;
    logic [N_EXT-1:0] s1_q, s2_q, last_q;

    assign tick     = (pre_q == PW'(PRESCALE - 1));
    assign ext_fall = {N_EXT{tick}} & last_q & ~s2_q;

    // Free-running prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Synchronise event inputs and remember their level at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            last_q <= '0;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
            if (tick) last_q <= s2_q;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_gap
            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
// One timer/counter: holds a low and a high byte and applies one count
// step according to the selected mode. Software writes override counting.
// Assumes step/step_aux are single-cycle enables already qualified by run
// and gate. HAS_SPLIT enables the two-byte split arrangement.
module tmr_core
    import tmr_pkg::*;
#(
    parameter bit HAS_SPLIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_mode_e         mode,
    input  logic              step,
    input  logic              step_aux,
    input  logic              hold,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf,
    output logic              ovf_aux
);
    localparam int PS_W = 5;
    localparam int W13  = BYTE_W + PS_W;
    localparam int W16  = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_n, hi_n;
    logic [W13:0]      sum13;
    logic [W16:0]      sum16;
    logic [BYTE_W:0]   sum_lo, sum_hi;

    assign sum13  = {1'b0, hi_q, lo_q[PS_W-1:0]} + 1'b1;
    assign sum16  = {1'b0, hi_q, lo_q} + 1'b1;
    assign sum_lo = {1'b0, lo_q} + 1'b1;
    assign sum_hi = {1'b0, hi_q} + 1'b1;

    // Next count and wrap pulses for the selected mode.
    always_comb begin
        lo_n    = lo_q;
        hi_n    = hi_q;
        ovf     = 1'b0;
        ovf_aux = 1'b0;
        if (!hold) begin
            unique case (mode)
                CM_13BIT: if (step) begin
                    lo_n[PS_W-1:0] = sum13[PS_W-1:0];
                    hi_n           = sum13[W13-1:PS_W];
                    ovf            = sum13[W13];
                end
                CM_16BIT: if (step) begin
                    {hi_n, lo_n} = sum16[W16-1:0];
                    ovf          = sum16[W16];
                end
                CM_RELOAD8: if (step) begin
                    lo_n = sum_lo[BYTE_W] ? hi_q : sum_lo[BYTE_W-1:0];
                    ovf  = sum_lo[BYTE_W];
                end
                CM_SPLIT: if (HAS_SPLIT) begin
                    if (step) begin
                        lo_n = sum_lo[BYTE_W-1:0];
                        ovf  = sum_lo[BYTE_W];
                    end
                    if (step_aux) begin
                        hi_n    = sum_hi[BYTE_W-1:0];
                        ovf_aux = sum_hi[BYTE_W];
                    end
                end
                default: ;
            endcase
        end
    end

    // Count registers; a software write takes priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wr_lo ? wdata : lo_n;
            hi_q <= wr_hi ? wdata : hi_n;
        end
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold || (!step && !step_aux)) && !wr_lo && !wr_hi)
        |=> ($stable(lo_q) && $stable(hi_q)));
    // R5
    wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && mode == CM_16BIT && step && {hi_q, lo_q} == '1 && !wr_lo && !wr_hi)
        |=> ({hi_q, lo_q} == '0));
    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_13BIT && !wr_lo) |=> (lo_q[BYTE_W-1:PS_W] == $past(lo_q[BYTE_W-1:PS_W])));
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && mode == CM_RELOAD8 && step && lo_q == '1 && !wr_lo && !wr_hi)
        |=> (lo_q == $past(hi_q) && $stable(hi_q)));
endmodule

// File: rtl/dual_timer_unit.sv
// Two timer/counters with a shared configuration byte and control byte.
// Decodes register writes, qualifies each timer's step by run, gate and
// source, routes the split arrangement, and keeps the wrap flags.
// Assumes single-cycle register access with a combinational read port.
module dual_timer_unit
    import tmr_pkg::*;
#(
    parameter int PRESCALE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [N_TMR-1:0]  ev_in,
    input  logic [N_TMR-1:0]  gate_lvl
);
    localparam int RUN_B = 4;

    logic [BYTE_W-1:0] cfg_q;
    logic [N_TMR-1:0]  run_q, flag_q, flag_set, ovf_m, ovf_a, ext_fall;
    logic [BYTE_W-1:0] lo_v [N_TMR];
    logic [BYTE_W-1:0] hi_v [N_TMR];
    tmr_cfg_t          cfg  [N_TMR];
    logic              tick, ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    tmr_tick_gen #(.PRESCALE(PRESCALE), .N_EXT(N_TMR)) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_in(ev_in),
        .tick(tick), .ext_fall(ext_fall)
    );

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            localparam logic [ADDR_W-1:0] A_LO = A_T0L + ADDR_W'(2 * i);
            logic en, evt, aux, hld;

            assign cfg[i] = tmr_cfg_t'(cfg_q[BYTE_W-1-CFG_W*i -: CFG_W]);
            assign en     = run_q[i] && (!cfg[i].gate || gate_lvl[i]);
            assign evt    = cfg[i].ext_sel ? ext_fall[i] : tick;
            if (i == 0) begin : g_first
                assign aux = tick && run_q[1];
                assign hld = 1'b0;
            end else begin : g_other
                assign aux = 1'b0;
                assign hld = (cfg[0].mode == CM_SPLIT) || (cfg[i].mode == CM_SPLIT);
            end

            tmr_core #(.HAS_SPLIT(i == 0)) u_core (
                .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
                .step(en && evt), .step_aux(aux), .hold(hld),
                .wr_lo(wr_en && wr_addr == A_LO),
                .wr_hi(wr_en && wr_addr == A_LO + 1'b1),
                .wdata(wr_data), .lo_q(lo_v[i]), .hi_q(hi_v[i]),
                .ovf(ovf_m[i]), .ovf_aux(ovf_a[i])
            );
        end
    endgenerate

    // Timer 1's flag is also set by timer 0's high byte in split mode.
    assign flag_set = {ovf_m[1] | ovf_a[0], ovf_m[0]};

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_q <= '0;
        else if (wr_en && wr_addr == A_CFG)  cfg_q <= wr_data;
    end

    // Run bits and wrap flags; a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            for (int i = 0; i < N_TMR; i++) begin
                if (ctrl_wr) begin
                    run_q[i]  <= wr_data[RUN_B + 2*i];
                    flag_q[i] <= wr_data[RUN_B + 2*i + 1] | flag_set[i];
                end else begin
                    flag_q[i] <= flag_q[i] | flag_set[i];
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rd_addr)
            3'd0:    rd_data = cfg_q;
            3'd1:    rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            3'd2:    rd_data = lo_v[0];
            3'd3:    rd_data = hi_v[0];
            3'd4:    rd_data = lo_v[1];
            3'd5:    rd_data = hi_v[1];
            default: rd_data = '0;
        endcase
    end

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !ctrl_wr) |=> flag_q[0]);
    // R5
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[0] && !ctrl_wr && !ovf_m[0]) |=> !flag_q[0]);
    // R11
    t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[0].mode == CM_SPLIT && !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)))
        |=> ($stable(lo_v[1]) && $stable(hi_v[1])));
endmodule

// File: tb/dual_timer_unit_test.sv
`timescale 1ns/1ps
module dual_timer_unit_test;
    localparam int TK = 12;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] ev_in = '0, gate_lvl = '0;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dual_timer_unit #(.PRESCALE(TK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_in(ev_in), .gate_lvl(gate_lvl)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a; #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: addr %0d actual %02h expected %02h", tag, a, rd_data, exp);
        end
    endtask

    // Opens a run window of exactly n ticks, checks control before closing.
    task automatic window(input logic [7:0] runv, input int n, input logic [7:0] exp_ctrl,
                          input string tag);
        wr(3'd1, runv);
        repeat (TK * n - 1) @(negedge clk);
        chk(3'd1, exp_ctrl, tag);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, "R1 reset value");
    endtask

    task automatic t_regs();
        wr(3'd0, 8'h5A); chk(3'd0, 8'h5A, "R2 config readback");
        wr(3'd1, 8'h0F); chk(3'd1, 8'h00, "R2 control low bits read zero");
        wr(3'd5, 8'hC3); chk(3'd5, 8'hC3, "R2 timer1 high readback");
        wr(3'd0, 8'h00); wr(3'd5, 8'h00);
    endtask

    task automatic t_mode16();
        wr(3'd0, 8'h10); wr(3'd2, 8'hFE); wr(3'd3, 8'h00);
        window(8'h10, 5, 8'h10, "R3 running, no flag");
        chk(3'd2, 8'h03, "R3 five ticks low"); chk(3'd3, 8'h01, "R3 five ticks high");
        repeat (30) @(negedge clk);
        chk(3'd2, 8'h03, "R4 stopped low holds"); chk(3'd3, 8'h01, "R4 stopped high holds");
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        window(8'h10, 3, 8'h30, "R5 flag set and kept");
        chk(3'd2, 8'h01, "R5 wrap low"); chk(3'd3, 8'h00, "R5 wrap high");
        chk(3'd1, 8'h00, "R5 software clear");
    endtask

    task automatic t_mode13();
        wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'h00);
        window(8'h10, 3, 8'h10, "R6 no flag");
        chk(3'd2, 8'hE1, "R6 prescaler carry, upper bits kept"); chk(3'd3, 8'h01, "R6 high step");
        wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
        window(8'h10, 2, 8'h30, "R6 wrap flag");
        chk(3'd2, 8'h01, "R6 wrap low"); chk(3'd3, 8'h00, "R6 wrap high");
    endtask

    task automatic t_reload();
        wr(3'd0, 8'h20); wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
        window(8'h10, 4, 8'h30, "R7 reload flag");
        chk(3'd2, 8'h82, "R7 reloaded low"); chk(3'd3, 8'h80, "R7 high unchanged");
    endtask

    task automatic t_gate();
        wr(3'd0, 8'h90); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gate_lvl = 2'b00;
        window(8'h10, 4, 8'h10, "R10 run bit");
        chk(3'd2, 8'h00, "R10 gate low blocks");
        gate_lvl = 2'b01;
        window(8'h10, 4, 8'h10, "R10 run bit");
        chk(3'd2, 8'h04, "R10 gate high counts");
        gate_lvl = 2'b00;
    endtask

    task automatic t_ext();
        wr(3'd0, 8'h05); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h40);
        ev_in[1] = 1'b1; repeat (36) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            ev_in[1] = 1'b0; repeat (36) @(negedge clk);
            ev_in[1] = 1'b1; repeat (36) @(negedge clk);
        end
        wr(3'd1, 8'h00);
        chk(3'd4, 8'h03, "R9 three falling edges"); chk(3'd5, 8'h00, "R9 high byte");
        ev_in[1] = 1'b0;
    endtask

    task automatic t_split();
        wr(3'd0, 8'h31); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h10); wr(3'd5, 8'h00);
        window(8'h50, 3, 8'hF0, "R8 both flags");
        chk(3'd2, 8'h01, "R8 low byte"); chk(3'd3, 8'h02, "R8 high byte on timer1 run");
        chk(3'd4, 8'h10, "R11 timer1 low held"); chk(3'd5, 8'h00, "R11 timer1 high held");
    endtask

    task automatic t_t1hold();
        wr(3'd0, 8'h03); wr(3'd4, 8'h20); wr(3'd5, 8'h00);
        window(8'h40, 2, 8'h40, "R11 no flag");
        chk(3'd4, 8'h20, "R11 own mode 11 holds");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mode16();
        t_mode13();
        t_reload();
        t_gate();
        t_ext();
        t_split();
        t_t1hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule